// File: doc/BRIEF.md
# USB Device Control and Interrupt Register

This block is the top control word of a USB device-side controller. It is read and written through a plain 32-bit register port. It holds four software-owned control bits: a controller enable, a resume mask that is stored only, a shared suspend/resume interrupt mask and a bus-reset interrupt mask. It also shows a read-only activity indication taken straight from an input. Three sticky host-event flags record a bus reset, a suspend and a resume. Software clears each flag by writing 1 to it.

The bus-signalling logic delivers single-cycle pulses for the three host events. The block drives one level-sensitive interrupt request, formed from the registered flags and their masks. A host bus reset returns the controller's own state to its defaults. The bus-reset flag is the exception: it stays set, so software can see afterwards that the reset took place.

Top module: `usb_dev_ctrl_reg`

## Requirements
- R1: After asynchronous reset the register reads 0x000000A0 with `active_i` low, and `enable_o` is 0.
- R2: Bits 0 (enable), 2 (resume mask), 5 (suspend/resume mask) and 7 (bus-reset mask) take the written value one cycle after a write. `enable_o` always equals bit 0.
- R3: Bit 1 always reads the current level of `active_i`. Writes to bit 1 are ignored.
- R4: Bits 31:8 always read 0. Writes to them are ignored.
- R5: A pulse on `suspend_i` sets bit 4, a pulse on `resume_i` sets bit 3 and a pulse on `bus_reset_i` sets bit 6. Each flag is set whatever the state of its mask.
- R6: Writing 1 to bit 6, 4 or 3 clears that flag on the next cycle. Writing 0 to it leaves it unchanged.
- R7: If a set pulse and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when (bit 6 and not bit 7) or ((bit 4 or bit 3) and not bit 5). It is valid in the same cycle as the flags it depends on.
- R9: A `bus_reset_i` pulse returns bits 0, 2, 5 and 7 to 0, 0, 1 and 1 and clears bits 4 and 3. This takes priority over a write and over suspend or resume pulses in the same cycle, and bit 6 ends up set.
- R10: A write with bit 6 at 0 never changes bit 6, whatever it does to the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register value |
| active_i | input | 1 | Activity indication shown at bit 1 |
| bus_reset_i | input | 1 | Host bus-reset event pulse |
| suspend_i | input | 1 | Host suspend event pulse |
| resume_i | input | 1 | Host resume event pulse |
| enable_o | output | 1 | Controller enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench checks that a bus-reset pulse clears everything except its own flag. A design that cleared that flag as well would read bit 6 low after the reset. The bench sends an event pulse and a write-1-to-clear to the same flag in the same cycle. A design that gave the clear priority would drop the event. Every combination of flags and masks is built and `irq_o` is compared against it. This exposes a resume flag gated by the wrong mask, and flags that stop updating while masked. A long pseudo-random sweep mixes writes, reserved-bit data and overlapping event pulses, and compares every cycle against a model built from the requirements.

// File: rtl/usb_ctrl_pkg.sv
package usb_ctrl_pkg;
  localparam int unsigned BIT_EN     = 0;
  localparam int unsigned BIT_ACT    = 1;
  localparam int unsigned BIT_RMASK  = 2;
  localparam int unsigned BIT_RES    = 3;
  localparam int unsigned BIT_SUS    = 4;
  localparam int unsigned BIT_SRMASK = 5;
  localparam int unsigned BIT_RST    = 6;
  localparam int unsigned BIT_RSTMSK = 7;
  localparam int unsigned USED_BITS  = 8;

  localparam int unsigned NUM_FLAGS  = 3;
  localparam int unsigned FLG_RES    = 0;
  localparam int unsigned FLG_SUS    = 1;
  localparam int unsigned FLG_RST    = 2;

  typedef struct packed {
    logic rst_mask;
    logic sr_mask;
    logic res_mask;
    logic enable;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{rst_mask: 1'b1, sr_mask: 1'b1, res_mask: 1'b0, enable: 1'b0};
endpackage

// File: rtl/usb_evt_flag.sv
module usb_evt_flag #(
  parameter bit KEEP_ON_BUS_RESET = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic bus_rst_i,
  output logic q_o
);
  logic q_d;

  generate
    if (KEEP_ON_BUS_RESET) begin : g_keep
      always_comb begin
        q_d = q_o;
        if (set_i)      q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
      end
    end else begin : g_clear
      // bus reset beats both a set and a clear
      always_comb begin
        q_d = q_o;
        if (bus_rst_i)  q_d = 1'b0;
        else if (set_i) q_d = 1'b1;
        else if (clr_i) q_d = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/usb_ctrl_fields.sv
module usb_ctrl_fields
  import usb_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bus_rst_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_d;
  ctrl_t wr_val;

  always_comb begin
    wr_val.enable   = wr_data_i[BIT_EN];
    wr_val.res_mask = wr_data_i[BIT_RMASK];
    wr_val.sr_mask  = wr_data_i[BIT_SRMASK];
    wr_val.rst_mask = wr_data_i[BIT_RSTMSK];
  end

  always_comb begin
    ctrl_d = ctrl_o;
    if (bus_rst_i)    ctrl_d = CTRL_RESET;
    else if (wr_en_i) ctrl_d = wr_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_o <= CTRL_RESET;
    else         ctrl_o <= ctrl_d;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[DATA_W-1:BIT_RSTMSK+1], wr_data_i[BIT_RST],
                            wr_data_i[BIT_SUS:BIT_RES], wr_data_i[BIT_ACT]};
endmodule

// File: rtl/usb_irq_gen.sv
module usb_irq_gen
  import usb_ctrl_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  ctrl_t                ctrl_i,
  output logic                 irq_o
);
  logic rst_req, sr_req;

  always_comb begin
    rst_req = flags_i[FLG_RST] & ~ctrl_i.rst_mask;
    sr_req  = (flags_i[FLG_SUS] | flags_i[FLG_RES]) & ~ctrl_i.sr_mask;
    irq_o   = rst_req | sr_req;
  end
endmodule

// File: rtl/usb_dev_ctrl_reg.sv
module usb_dev_ctrl_reg
  import usb_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              active_i,
  input  logic              bus_reset_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic              enable_o,
  output logic              irq_o
);
  localparam logic [NUM_FLAGS-1:0] KEEP_MASK = NUM_FLAGS'(1) << FLG_RST;
  localparam int unsigned          RSV_W     = DATA_W - USED_BITS;

  ctrl_t                ctrl_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_RES] = resume_i;
    flag_set[FLG_SUS] = suspend_i;
    flag_set[FLG_RST] = bus_reset_i;
    flag_clr          = '0;
    flag_clr[FLG_RES] = wr_en_i & wr_data_i[BIT_RES];
    flag_clr[FLG_SUS] = wr_en_i & wr_data_i[BIT_SUS];
    flag_clr[FLG_RST] = wr_en_i & wr_data_i[BIT_RST];
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    usb_evt_flag #(.KEEP_ON_BUS_RESET(KEEP_MASK[i])) u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (flag_set[i]),
      .clr_i    (flag_clr[i]),
      .bus_rst_i(bus_reset_i),
      .q_o      (flag_q[i])
    );
  end

  usb_ctrl_fields #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .bus_rst_i(bus_reset_i),
    .ctrl_o   (ctrl_q)
  );

  usb_irq_gen u_irq (
    .flags_i(flag_q),
    .ctrl_i (ctrl_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[BIT_EN]     = ctrl_q.enable;
    rd_data_o[BIT_ACT]    = active_i;
    rd_data_o[BIT_RMASK]  = ctrl_q.res_mask;
    rd_data_o[BIT_RES]    = flag_q[FLG_RES];
    rd_data_o[BIT_SUS]    = flag_q[FLG_SUS];
    rd_data_o[BIT_SRMASK] = ctrl_q.sr_mask;
    rd_data_o[BIT_RST]    = flag_q[FLG_RST];
    rd_data_o[BIT_RSTMSK] = ctrl_q.rst_mask;
  end

  assign enable_o = ctrl_q.enable;

  logic [RSV_W-1:0] unused_rsv;
  assign unused_rsv = wr_data_i[DATA_W-1:USED_BITS];
endmodule

// File: rtl/usb_dev_ctrl_reg_chk.sv
module usb_dev_ctrl_reg_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              bus_reset_i,
  input logic              suspend_i,
  input logic              resume_i,
  input logic              enable_o,
  input logic              irq_o
);
  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !bus_reset_i) |=> (rd_data_o[0] == $past(wr_data_i[0])) &&
      (rd_data_o[2] == $past(wr_data_i[2])) && (rd_data_o[5] == $past(wr_data_i[5])) &&
      (rd_data_o[7] == $past(wr_data_i[7])));

  assert_enable_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_o == rd_data_o[0]);

  assert_reserved_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:8] == '0);

  assert_suspend_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !bus_reset_i) |=> rd_data_o[4]);

  assert_resume_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !bus_reset_i) |=> rd_data_o[3]);

  assert_w1c_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[4] && !suspend_i) |=> !rd_data_o[4]);

  assert_w0_keeps_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[3] && !(wr_en_i && wr_data_i[3]) && !bus_reset_i) |=> rd_data_o[3]);

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && wr_en_i && wr_data_i[3] && !bus_reset_i) |=> rd_data_o[3]);

  assert_irq_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((rd_data_o[6] && !rd_data_o[7]) ||
              ((rd_data_o[4] || rd_data_o[3]) && !rd_data_o[5])));

  assert_bus_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> rd_data_o[6] && rd_data_o[7] && rd_data_o[5] && !rd_data_o[4] &&
      !rd_data_o[3] && !rd_data_o[2] && !rd_data_o[0]);

  assert_rst_flag_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_data_i[6] && !bus_reset_i) |=> rd_data_o[6] == $past(rd_data_o[6]));

  logic unused_wr;
  assign unused_wr = ^wr_data_i;
endmodule

bind usb_dev_ctrl_reg usb_dev_ctrl_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .bus_reset_i(bus_reset_i),
  .suspend_i  (suspend_i),
  .resume_i   (resume_i),
  .enable_o   (enable_o),
  .irq_o      (irq_o)
);

// File: tb/usb_dev_ctrl_reg_test.sv
module usb_dev_ctrl_reg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        active_i = 1'b0;
  logic        bus_reset_i = 1'b0;
  logic        suspend_i = 1'b0;
  logic        resume_i = 1'b0;
  logic        enable_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;

  // bench model
  logic m_en = 1'b0, m_rm = 1'b0, m_srm = 1'b1, m_rem = 1'b1;
  logic m_rst = 1'b0, m_sus = 1'b0, m_res = 1'b0;

  usb_dev_ctrl_reg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .active_i(active_i), .bus_reset_i(bus_reset_i),
    .suspend_i(suspend_i), .resume_i(resume_i), .enable_o(enable_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check_all(input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd  = {24'h0, m_rem, m_rst, m_srm, m_sus, m_res, m_rm, active_i, m_en};
    exp_irq = (m_rst & ~m_rem) | ((m_sus | m_res) & ~m_srm);
    checks++;
    if (rd_data_o !== exp_rd || irq_o !== exp_irq || enable_o !== m_en) begin
      failures++;
      $display("FAIL %s rd=%h irq=%b en=%b expected rd=%h irq=%b en=%b",
               tag, rd_data_o, irq_o, enable_o, exp_rd, exp_irq, m_en);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] wd, input logic br,
                      input logic su, input logic re, input logic act, input string tag);
    wr_en_i = we; wr_data_i = wd; bus_reset_i = br;
    suspend_i = su; resume_i = re; active_i = act;
    @(posedge clk_i); #1;
    if (br) begin
      m_en = 1'b0; m_rm = 1'b0; m_srm = 1'b1; m_rem = 1'b1;
      m_sus = 1'b0; m_res = 1'b0; m_rst = 1'b1;
    end else begin
      if (we) begin
        m_en = wd[0]; m_rm = wd[2]; m_srm = wd[5]; m_rem = wd[7];
      end
      m_rst = m_rst & ~(we & wd[6]);
      m_sus = su | (m_sus & ~(we & wd[4]));
      m_res = re | (m_res & ~(we & wd[3]));
    end
    wr_en_i = 1'b0; bus_reset_i = 1'b0; suspend_i = 1'b0; resume_i = 1'b0;
    #1;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    #(CLK_PERIOD * 3 + 1);
    check_all("R1 reset value 0xA0");
    rst_ni = 1'b1;
    #(CLK_PERIOD * 2);
    check_all("R1 after release");

    // R2 every pattern of the control bits; R3 active and bit1 writes; R4 reserved writes
    for (int i = 0; i < 16; i++) begin
      logic [31:0] wd;
      wd = 32'hFFFF_FF00 | {24'h0, i[3], 1'b0, i[2], 2'b00, i[1], 1'b1, i[0]};
      step(1'b1, wd, 1'b0, 1'b0, 1'b0, i[0], "R2 R3 R4 control write sweep");
    end
    active_i = 1'b1; #1; check_all("R3 active high reads back");
    active_i = 1'b0; #1; check_all("R3 active low reads back");

    // R5 flags set while masked
    step(1'b1, 32'h0000_00A0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 suspend sets while masked");
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 resume sets while masked");
    step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R8 unmask raises irq");
    step(1'b1, 32'h0000_0010, 1'b0, 1'b0, 1'b0, 1'b0, "R6 w1c suspend only");
    step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R6 write 0 keeps resume");
    step(1'b1, 32'h0000_0008, 1'b0, 1'b0, 1'b1, 1'b0, "R7 resume set beats w1c");
    step(1'b1, 32'h0000_0010, 1'b0, 1'b1, 1'b0, 1'b0, "R7 suspend set beats w1c");
    // R9 bus reset beats write and events, keeps own flag
    step(1'b1, 32'h0000_0025, 1'b1, 1'b1, 1'b1, 1'b0, "R9 bus reset restores defaults");
    step(1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R8 R10 unmask keeps reset flag");
    step(1'b1, 32'h0000_00C0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 bus reset set beats w1c");
    step(1'b1, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 1'b0, "R10 mask write keeps flag");
    step(1'b1, 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b0, "R6 w1c reset flag");

    // R8 every flag and mask combination
    for (int m = 0; m < 32; m++) begin
      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 setup bus reset");
      if (!m[0]) step(1'b1, 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b0, "R6 setup clear");
      step(1'b1, {24'h0, m[3], 1'b0, m[4], 5'b0}, 1'b0, m[1], m[2], 1'b1,
           "R8 irq flag mask sweep");
    end

    // mixed pseudo-random sweep
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step(lf[0], {lf[31:8] ^ lf[23:0], lf[15:8]}, lf[4:1] == 4'hF, lf[5] & lf[6],
           lf[7] & lf[8], lf[9], "R2 R5 R6 R7 R8 R9 R10 random sweep");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule